// File: doc/BRIEF.md
# Multi-Source Chip Reset Controller

This block merges three kinds of reset request into a single active-high chip reset. The three requests are supply power-on, an active-low external reset pin, and three per-rail low-voltage flags. It runs on a free-running oscillator clock. Its inputs are comparator outputs that are already digital but not yet synchronous. Each input is first synchronized. Each request is then qualified by the time it persists, and that time can differ for the asserting and the releasing direction. Every duration is a parameter counted in clock cycles.

The supply path produces two signals. The first is a supply-good level with hysteresis in time: a brief dip in the supply does not clear it. The second is a power-on pulse that stays high for a short stretch after the supply becomes good. After every request has gone quiet, the chip reset stays high for a long configuration settling period. Any request that arrives during that period starts the period again. A three-bit cause vector shows which requests have fired since the last power-up.

Top module: `chip_reset_ctrl`

## Requirements
- R1: Supply-good rises only after the above-high-trip flag has been true for T_HIGH consecutive cycles. With the two-stage synchronizer it rises on the (T_HIGH+2)th rising edge after the flag is set.
- R2: While supply-good is high, it falls only after the below-low-trip flag has been true for T_LOW consecutive cycles, on the (T_LOW+2)th edge. A shorter dip changes nothing: supply-good, the power-on pulse and the chip reset all stay as they were.
- R3: The power-on pulse is 1 whenever supply-good is 0. It stays 1 for exactly T_PULSE edges after supply-good rises, then drops to 0. It fires again after every real power-down.
- R4: The external pin is active low. Its request asserts on the (T_RSTL+2)th edge after the pin goes low. It releases on the (T_RSTH+2)th edge after the pin returns high. A low pulse shorter than T_RSTL cycles is ignored.
- R5: Rail flag bit 0 is the 0.9 V rail, bit 1 the 1.2 V rail and bit 2 the 1.5 V rail. They need T_LV09, T_LV12 and T_LV15 consecutive cycles respectively before they request reset. Each request releases on the third edge after its flag drops.
- R6: The chip reset is 1 while any request is active, where the power-on pulse counts as a request. It falls exactly T_MODE edges after the last request clears. A request arriving during the hold restarts the count.
- R7: Cause bits are: bit 0 power-on, bit 1 external pin, bit 2 low voltage. When supply-good rises, the vector is loaded with 3'b001. A qualified external or low-voltage request sets its bit one edge after it asserts. Bits are cleared only at the next power-up.
- R8: During and after the synchronous reset input, the outputs are: supply-good 0, power-on pulse 1, chip reset 1, cause 3'b000.
- R9: Persistence counts do not accumulate across interruptions. Two low pulses on the pin, each T_RSTL-1 cycles long and separated by one high cycle, cause no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's flops |
| sup_above_hi_i | input | 1 | Supply is above the high trip level (asynchronous) |
| sup_below_lo_i | input | 1 | Supply is below the low trip level (asynchronous) |
| pin_rst_n_i | input | 1 | Schmitt-buffered external reset pin, active low |
| rail_low_i | input | 3 | Low-voltage flags: [0] 0.9 V, [1] 1.2 V, [2] 1.5 V |
| chip_rst_o | output | 1 | Qualified chip reset, active high |
| supply_good_o | output | 1 | Qualified supply-good level |
| por_pulse_o | output | 1 | Power-on pulse |
| rst_cause_o | output | 3 | Sticky cause vector since the last power-up |

## Verification
The bench builds the block with very short durations. These are T_HIGH=4, T_LOW=6, T_PULSE=3, T_RSTL=3, T_RSTH=5, rail times 2/3/5 and T_MODE=7. With these values, every pulse length from one cycle to one past each threshold can be swept, and the outcome checked against the arithmetic rule "length ≥ threshold". The exact release edges can be checked too. The short hold also lets the bench place a second request inside an unexpired hold, and then run a full power-down and power-up to check that the pulse re-fires and the cause bits are cleared.

// File: rtl/rstc_pkg.sv
// Package: shared constants for the chip reset controller.
// Assumes: three request classes and three monitored rails.
package rstc_pkg;
    localparam int NSRC   = 3;
    localparam int NRAIL  = 3;
    localparam int SRC_POR = 0;
    localparam int SRC_EXT = 1;
    localparam int SRC_LV  = 2;
    // synchronizer lane positions
    localparam int SY_ABOVE = 0;
    localparam int SY_BELOW = 1;
    localparam int SY_PIN   = 2;
    localparam int SY_RAIL  = 3;
    localparam int SY_W     = SY_RAIL + NRAIL;
    typedef logic [NSRC-1:0] cause_t;
endpackage

// File: rtl/rstc_sync.sv
// Module: rstc_sync
// Two-flop synchronizer for a vector of independent asynchronous flags.
// Assumes: each bit is sampled on its own; no coherency between bits is needed.
module rstc_sync #(
    parameter int          W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // two-stage capture into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q_o  <= RST_VAL;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/rstc_qual.sv
// Module: rstc_qual
// Persistence qualifier: the output follows the input only after the input
// has differed from it for ON_CYC (rising) or OFF_CYC (falling) consecutive
// cycles. Any cycle of agreement clears the run count.
// Assumes: input already synchronous; ON_CYC and OFF_CYC are at least 1.
module rstc_qual #(
    parameter int unsigned ON_CYC  = 4,
    parameter int unsigned OFF_CYC = 4,
    parameter bit          RST_Q   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic q_o
);
    localparam int unsigned MAXN = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int unsigned CW   = $clog2(MAXN + 1);

    logic [CW-1:0] run;
    logic [CW-1:0] last_idx;

    // terminal index depends on the direction of the pending change
    assign last_idx = q_o ? CW'(OFF_CYC - 1) : CW'(ON_CYC - 1);

    // count consecutive disagreeing cycles and flip at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_Q;
            run <= '0;
        end else if (in_i == q_o) begin
            run <= '0;
        end else if (run == last_idx) begin
            q_o <= in_i;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R9: output only moves after the input disagreed in the previous cycle
    p_flip_follows_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_o) |-> ($past(in_i) != $past(q_o)));
    // R9: run count never reaches the longer window length
    p_run_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run < CW'(MAXN));
endmodule

// File: rtl/rstc_stretch.sv
// Module: rstc_stretch
// Hold-off stretcher: busy while the trigger is high and for LEN cycles
// after it drops; a new trigger restarts the count from zero.
// Assumes: LEN is at least 1; starts busy out of reset.
module rstc_stretch #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // restart on trigger, otherwise count up to LEN and stay there
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (trig_i)
            cnt <= '0;
        else if (cnt != CW'(LEN))
            cnt <= cnt + 1'b1;
    end

    assign busy_o = trig_i | (cnt != CW'(LEN));

    // R6: busy can only re-appear because a trigger arrived
    p_busy_needs_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> trig_i);
    // R6: once released, a quiet trigger keeps it released
    p_stay_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !trig_i) |=> (busy_o == trig_i));
endmodule

// File: rtl/chip_reset_ctrl.sv
// Module: chip_reset_ctrl
// Combines supply power-on, an active-low pin and per-rail low-voltage flags
// into one qualified active-high chip reset, with a supply-good level, a
// stretched power-on pulse, a configuration hold and a sticky cause vector.
// Assumes: all flag inputs are asynchronous; durations are in clock cycles.
module chip_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned T_HIGH  = 200,
    parameter int unsigned T_LOW   = 1100,
    parameter int unsigned T_PULSE = 20,
    parameter int unsigned T_RSTL  = 100,
    parameter int unsigned T_RSTH  = 100,
    parameter int unsigned T_LV09  = 800,
    parameter int unsigned T_LV12  = 800,
    parameter int unsigned T_LV15  = 1600,
    parameter int unsigned T_MODE  = 1500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_above_hi_i,
    input  logic             sup_below_lo_i,
    input  logic             pin_rst_n_i,
    input  logic [NRAIL-1:0] rail_low_i,
    output logic             chip_rst_o,
    output logic             supply_good_o,
    output logic             por_pulse_o,
    output logic [NSRC-1:0]  rst_cause_o
);
    localparam logic [SY_W-1:0] SY_RST = SY_W'(1) << SY_PIN;

    function automatic int unsigned rail_len(input int idx);
        case (idx)
            0:       return T_LV09;
            1:       return T_LV12;
            default: return T_LV15;
        endcase
    endfunction

    logic [SY_W-1:0]  sy;
    logic             por_in;
    logic             pin_req;
    logic [NRAIL-1:0] rail_req;
    logic             any_req;
    logic             good_d, pin_d, rail_d;
    cause_t           cause;

    rstc_sync #(.W(SY_W), .RST_VAL(SY_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rail_low_i, pin_rst_n_i, sup_below_lo_i, sup_above_hi_i}),
        .q_o   (sy)
    );

    // supply path: watch the above flag while down, the below flag while up
    assign por_in = supply_good_o ? ~sy[SY_BELOW] : sy[SY_ABOVE];

    rstc_qual #(.ON_CYC(T_HIGH), .OFF_CYC(T_LOW), .RST_Q(1'b0)) u_qual_por (
        .clk(clk), .rst_n(rst_n), .in_i(por_in), .q_o(supply_good_o)
    );

    rstc_stretch #(.LEN(T_PULSE)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig_i(~supply_good_o), .busy_o(por_pulse_o)
    );

    rstc_qual #(.ON_CYC(T_RSTL), .OFF_CYC(T_RSTH), .RST_Q(1'b0)) u_qual_pin (
        .clk(clk), .rst_n(rst_n), .in_i(~sy[SY_PIN]), .q_o(pin_req)
    );

    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        rstc_qual #(.ON_CYC(rail_len(g)), .OFF_CYC(1), .RST_Q(1'b0)) u_qual_rail (
            .clk(clk), .rst_n(rst_n), .in_i(sy[SY_RAIL+g]), .q_o(rail_req[g])
        );
    end

    assign any_req = por_pulse_o | pin_req | (|rail_req);

    rstc_stretch #(.LEN(T_MODE)) u_hold (
        .clk(clk), .rst_n(rst_n), .trig_i(any_req), .busy_o(chip_rst_o)
    );

    // edge history for the cause vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_d <= 1'b0;
            pin_d  <= 1'b0;
            rail_d <= 1'b0;
        end else begin
            good_d <= supply_good_o;
            pin_d  <= pin_req;
            rail_d <= |rail_req;
        end
    end

    // sticky cause: reload on power-up, accumulate later requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (supply_good_o && !good_d) begin
            cause <= cause_t'(1) << SRC_POR;
        end else begin
            if (pin_req && !pin_d)
                cause[SRC_EXT] <= 1'b1;
            if ((|rail_req) && !rail_d)
                cause[SRC_LV] <= 1'b1;
        end
    end

    assign rst_cause_o = cause;

    // R6: no release while the supply is not good
    p_rst_while_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_o |-> chip_rst_o);
    // R3: pulse covers every moment the supply is not good
    p_pulse_while_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_o |-> por_pulse_o);
    // R3: pulse ends only with the supply good
    p_pulse_ends_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_pulse_o) |-> supply_good_o);
    // R6: release only when every request is quiet
    p_release_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst_o) |-> (!pin_req && rail_req == '0 && !por_pulse_o));
    // R7: power-up loads the power-on cause alone
    p_cause_powerup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_good_o) |=> (rst_cause_o == 3'b001));
endmodule

// File: tb/sim_chip_reset_ctrl.sv
`timescale 1ns/1ps
module sim_chip_reset_ctrl;
    localparam int TH = 4, TL = 6, TP = 3, TRL = 3, TRH = 5;
    localparam int L0 = 2, L1 = 3, L2 = 5, TM = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b1, pin_n = 1'b1;
    logic [2:0] rail = 3'b000;
    logic chip_rst, good, pp;
    logic [2:0] cause;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chip_reset_ctrl #(
        .T_HIGH(TH), .T_LOW(TL), .T_PULSE(TP), .T_RSTL(TRL), .T_RSTH(TRH),
        .T_LV09(L0), .T_LV12(L1), .T_LV15(L2), .T_MODE(TM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sup_above_hi_i(above), .sup_below_lo_i(below),
        .pin_rst_n_i(pin_n), .rail_low_i(rail), .chip_rst_o(chip_rst),
        .supply_good_o(good), .por_pulse_o(pp), .rst_cause_o(cause)
    );

    task automatic chk(input string req, input int got, input int exp, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int rail_len(input int i);
        return (i == 0) ? L0 : (i == 1) ? L1 : L2;
    endfunction

    // drive one stimulus for len cycles, then watch 6 more cycles
    task automatic pulse(input int sel, input int len,
                         output bit rst_rose, output bit good_fell, output bit pp_rose);
        rst_rose = 1'b0; good_fell = 1'b0; pp_rose = 1'b0;
        case (sel)
            0: begin above = 1'b0; below = 1'b1; end
            1: pin_n = 1'b0;
            default: rail[sel-2] = 1'b1;
        endcase
        for (int k = 0; k < len + 6; k++) begin
            if (k == len) begin
                above = 1'b1; below = 1'b0; pin_n = 1'b1; rail = 3'b000;
            end
            @(negedge clk);
            if (chip_rst) rst_rose = 1'b1;
            if (!good) good_fell = 1'b1;
            if (pp) pp_rose = 1'b1;
        end
    endtask

    task automatic wait_quiet();
        for (int k = 0; k < 200 && chip_rst; k++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog expired: got 0 expected 1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit rr, gf, pr;
        tick(4);
        // R8 reset state
        chk("R8", good, 0, "good in reset");
        chk("R8", pp, 1, "pulse in reset");
        chk("R8", chip_rst, 1, "chip reset in reset");
        chk("R8", cause, 0, "cause in reset");
        rst_n = 1'b1;
        tick(3);
        chk("R8", chip_rst, 1, "chip reset after release, supply down");

        // R1 power-up timing, R3 pulse, R6 hold, R7 cause
        above = 1'b1; below = 1'b0;
        tick(TH + 1);
        chk("R1", good, 0, "good one edge early");
        tick(1);
        chk("R1", good, 1, "good on edge T_HIGH+2");
        chk("R3", pp, 1, "pulse right after good");
        tick(TP - 1);
        chk("R3", pp, 1, "pulse one edge before end");
        chk("R7", cause, 3'b001, "cause after power-up");
        tick(1);
        chk("R3", pp, 0, "pulse ends after T_PULSE");
        tick(TM - 1);
        chk("R6", chip_rst, 1, "hold one edge early");
        tick(1);
        chk("R6", chip_rst, 0, "release after T_MODE");

        // R2 short dips ignored
        for (int len = 1; len < TL; len++) begin
            pulse(0, len, rr, gf, pr);
            chk("R2", gf, 0, $sformatf("good kept, dip %0d", len));
            chk("R2", pr, 0, $sformatf("no pulse, dip %0d", len));
            chk("R2", rr, 0, $sformatf("no reset, dip %0d", len));
        end

        // R4 pin low-time sweep
        for (int len = 1; len <= TRL + 1; len++) begin
            pulse(1, len, rr, gf, pr);
            chk("R4", rr, (len >= TRL) ? 1 : 0, $sformatf("pin low %0d", len));
            wait_quiet();
        end
        chk("R7", cause, 3'b011, "cause after pin reset");

        // R9 split low pulses do not add up
        pin_n = 1'b0; tick(TRL - 1);
        pin_n = 1'b1; tick(1);
        pin_n = 1'b0; tick(TRL - 1);
        pin_n = 1'b1;
        rr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (chip_rst) rr = 1'b1;
        end
        chk("R9", rr, 0, "split pin pulses");

        // R4 exact release edge
        pin_n = 1'b0; tick(10);
        chk("R4", chip_rst, 1, "held by pin");
        pin_n = 1'b1;
        tick(TRH + TM + 1);
        chk("R4", chip_rst, 1, "one edge before pin release");
        tick(1);
        chk("R4", chip_rst, 0, "release after T_RSTH+2+T_MODE");

        // R5 per-rail persistence sweeps
        for (int r = 0; r < 3; r++) begin
            for (int len = 1; len <= rail_len(r) + 1; len++) begin
                pulse(2 + r, len, rr, gf, pr);
                chk("R5", rr, (len >= rail_len(r)) ? 1 : 0,
                    $sformatf("rail %0d low for %0d", r, len));
                wait_quiet();
            end
        end
        chk("R7", cause, 3'b111, "cause after rail resets");

        // R6 hold restart by a new request
        pin_n = 1'b0; tick(10);
        pin_n = 1'b1;
        tick(TRH + 2 + 2);
        chk("R6", chip_rst, 1, "inside hold");
        rail[0] = 1'b1;
        tick(5);
        rail[0] = 1'b0;
        tick(2 + TM);
        chk("R6", chip_rst, 1, "restarted hold one edge early");
        tick(1);
        chk("R6", chip_rst, 0, "restarted hold release");

        // R2 real power-down, R3 re-fire, R7 clear on power-up
        above = 1'b0; below = 1'b1;
        tick(TL + 1);
        chk("R2", good, 1, "good one edge before fall");
        tick(1);
        chk("R2", good, 0, "good falls on T_LOW+2");
        chk("R3", pp, 1, "pulse re-fires");
        chk("R6", chip_rst, 1, "reset on power-down");
        chk("R7", cause, 3'b111, "cause sticky while down");
        above = 1'b1; below = 1'b0;
        tick(TH + 2);
        chk("R1", good, 1, "good back");
        tick(1);
        chk("R7", cause, 3'b001, "cause cleared by power-up");
        tick(TP - 1);
        chk("R3", pp, 0, "pulse ends again");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule